// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block turns a 4 KiB memory-mapped window into accesses on an IDE task-file register port. Every register takes a 16-byte slot in the window. A host issues byte, halfword or word reads and writes. The bridge works out which slot and which access size the host used, and from those it chooses one of four targets:

- one of the seven task-file registers,
- the status-read / device-control pair,
- the 16- or 32-bit data port,
- nothing at all.

The data port sits on the far side of a byte-order boundary. The bridge therefore reverses the byte order of halfword and word data in both directions. A read that lands on an unmapped slot returns all ones.

The device side is a set of single-cycle strobes that act combinationally on the host request: read and write strobes with an index for the task-file registers, a status read strobe, a device-control write strobe, and data-port read and write strobes with a width flag. The host read data is captured in a register and presented, together with a valid flag, in the cycle after the read strobe.

Top module: `mmio_ide_bridge`

## Requirements
- R1: The slot index is address bits [11:4]. Address bits above bit 11 and below bit 4 have no effect, so the window repeats every 4 KiB.
- R2: A byte access (size code 00) to slot 1 to 7 raises `dev_reg_rd` or `dev_reg_wr` for exactly one clock, with `dev_reg_idx` equal to the slot number. Byte write data travels on bits [7:0]. A byte read returns the register value in `host_rdata[7:0]` with bits [31:8] zero.
- R3: A byte write to slot 8 or slot 22 raises `dev_ctl_wr` with the write byte. A byte read from either slot raises `dev_stat_rd` and returns the status byte.
- R4: A byte read from any other slot (including slot 0) returns 0x000000FF. A byte write to such a slot raises no device strobe.
- R5: Halfword (size 01) and word (size 10) accesses reach the data port only at slot 0. `dev_data_wide` is 0 for a halfword and 1 for a word.
- R6: For a halfword access, the host's bits [7:0] and [15:8] trade places in both directions. The port write data has bits [31:16] zero, and the host read data has bits [31:16] zero.
- R7: For a word access, the four bytes are reversed in both directions: host byte 0 goes to port byte 3, and so on.
- R8: Halfword reads of a slot other than 0 return 0x0000FFFF. Word reads of such a slot, and any read with size code 11, return 0xFFFFFFFF. Such writes raise no device strobe.
- R9: `host_rvalid` is high for exactly the one cycle after each accepted read strobe, and `host_rdata` holds the read result in that cycle.
- R10: When `host_rd` and `host_wr` are high in the same cycle, only the write is carried out. No read strobe reaches the device and `host_rvalid` stays low in the following cycle.
- R11: After a synchronous active-high reset, `host_rvalid` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| dev_reg_idx | output | 3 | Task-file register index |
| dev_reg_rd | output | 1 | Task-file read strobe |
| dev_reg_wr | output | 1 | Task-file write strobe |
| dev_reg_wdata | output | 8 | Task-file write byte |
| dev_reg_rdata | input | 8 | Task-file read byte |
| dev_stat_rd | output | 1 | Status read strobe |
| dev_stat_rdata | input | 8 | Status byte |
| dev_ctl_wr | output | 1 | Device-control write strobe |
| dev_ctl_wdata | output | 8 | Device-control write byte |
| dev_data_rd | output | 1 | Data-port read strobe |
| dev_data_wr | output | 1 | Data-port write strobe |
| dev_data_wide | output | 1 | 1 for a 32-bit data-port access, 0 for 16-bit |
| dev_data_wdata | output | 32 | Byte-swapped data-port write data |
| dev_data_rdata | input | 32 | Data-port read data, device byte order |

## Verification
A read strobe and a write strobe can land in the same cycle. The decode must then pick one of them and must not produce two device strobes or a stale read result. The bench raises `host_rd` and `host_wr` together on a task-file slot. It then checks three things: the stub register took the written byte, the stub counted exactly one device strobe, and `host_rvalid` stayed low in the following cycle.

// File: rtl/mmio_ide_pkg.sv
package mmio_ide_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTST = 2'd2,
    TGT_DATA = 2'd3
  } target_e;

endpackage

// File: rtl/ide_slot_decode.sv
module ide_slot_decode
  import mmio_ide_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int TF_LAST    = 7,
  parameter int CTL_SLOT_A = 8,
  parameter int CTL_SLOT_B = 22
) (
  input  logic [IDX_W-1:0] slot,
  input  logic [1:0]       size,
  output target_e          target
);

  always_comb begin
    target = TGT_NONE;
    if (size == SZ_BYTE) begin
      if (slot >= IDX_W'(1) && slot <= IDX_W'(TF_LAST))
        target = TGT_TASK;
      else if (slot == IDX_W'(CTL_SLOT_A) || slot == IDX_W'(CTL_SLOT_B))
        target = TGT_CTST;
    end else if ((size == SZ_HALF || size == SZ_WORD) && slot == '0) begin
      target = TGT_DATA;
    end
  end

endmodule

// File: rtl/ide_byte_swap.sv
module ide_byte_swap #(
  parameter int BYTES = 2
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
  end

endmodule

// File: rtl/mmio_ide_bridge.sv
module mmio_ide_bridge
  import mmio_ide_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WINDOW_BITS = 12,
  parameter int SLOT_SHIFT  = 4,
  parameter int CTL_SLOT_A  = 8,
  parameter int CTL_SLOT_B  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic [2:0]        dev_reg_idx,
  output logic              dev_reg_rd,
  output logic              dev_reg_wr,
  output logic [7:0]        dev_reg_wdata,
  input  logic [7:0]        dev_reg_rdata,
  output logic              dev_stat_rd,
  input  logic [7:0]        dev_stat_rdata,
  output logic              dev_ctl_wr,
  output logic [7:0]        dev_ctl_wdata,
  output logic              dev_data_rd,
  output logic              dev_data_wr,
  output logic              dev_data_wide,
  output logic [31:0]       dev_data_wdata,
  input  logic [31:0]       dev_data_rdata
);

  localparam int IDX_W = WINDOW_BITS - SLOT_SHIFT;

  logic [IDX_W-1:0] slot;
  target_e          target;
  logic             wr_go, rd_go;
  logic [15:0]      sw16_w, sw16_r;
  logic [31:0]      sw32_w, sw32_r;
  logic [31:0]      rd_next;
  logic             unused_bits;

  assign slot        = host_addr[WINDOW_BITS-1:SLOT_SHIFT];
  assign unused_bits = ^{host_addr[ADDR_W-1:WINDOW_BITS], host_addr[SLOT_SHIFT-1:0]};

  ide_slot_decode #(
    .IDX_W(IDX_W), .TF_LAST(7), .CTL_SLOT_A(CTL_SLOT_A), .CTL_SLOT_B(CTL_SLOT_B)
  ) u_dec (
    .slot(slot), .size(host_size), .target(target)
  );

  ide_byte_swap #(.BYTES(2)) u_sw16_w (.din(host_wdata[15:0]),     .dout(sw16_w));
  ide_byte_swap #(.BYTES(2)) u_sw16_r (.din(dev_data_rdata[15:0]), .dout(sw16_r));
  ide_byte_swap #(.BYTES(4)) u_sw32_w (.din(host_wdata),           .dout(sw32_w));
  ide_byte_swap #(.BYTES(4)) u_sw32_r (.din(dev_data_rdata),       .dout(sw32_r));

  // a write wins over a read raised in the same cycle
  assign wr_go = host_wr;
  assign rd_go = host_rd && !host_wr;

  assign dev_reg_idx    = slot[2:0];
  assign dev_reg_rd     = rd_go && target == TGT_TASK;
  assign dev_reg_wr     = wr_go && target == TGT_TASK;
  assign dev_reg_wdata  = host_wdata[7:0];
  assign dev_stat_rd    = rd_go && target == TGT_CTST;
  assign dev_ctl_wr     = wr_go && target == TGT_CTST;
  assign dev_ctl_wdata  = host_wdata[7:0];
  assign dev_data_rd    = rd_go && target == TGT_DATA;
  assign dev_data_wr    = wr_go && target == TGT_DATA;
  assign dev_data_wide  = host_size == SZ_WORD;
  assign dev_data_wdata = dev_data_wide ? sw32_w : {16'h0000, sw16_w};

  always_comb begin
    unique case (target)
      TGT_TASK: rd_next = {24'h0, dev_reg_rdata};
      TGT_CTST: rd_next = {24'h0, dev_stat_rdata};
      TGT_DATA: rd_next = dev_data_wide ? sw32_r : {16'h0000, sw16_r};
      default: begin
        // all-ones default; swapping it afterwards would not change it
        if (host_size == SZ_BYTE)      rd_next = 32'h0000_00FF;
        else if (host_size == SZ_HALF) rd_next = 32'h0000_FFFF;
        else                           rd_next = 32'hFFFF_FFFF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_go;
      if (rd_go) host_rdata <= rd_next;
    end
  end

  // R2 R3 R5: at most one device strobe per cycle
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dev_reg_rd, dev_reg_wr, dev_stat_rd, dev_ctl_wr, dev_data_rd, dev_data_wr}));

  // R4 R8: no device strobe without a host strobe
  assert_no_idle_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(host_rd || host_wr) |->
      !(dev_reg_rd || dev_reg_wr || dev_stat_rd || dev_ctl_wr || dev_data_rd || dev_data_wr));

  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> host_rvalid);

  assert_collide_no_read_R10: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_wr) |=> !host_rvalid);

  assert_unmapped_byte_R4: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr && host_size == 2'b00 && !dev_reg_rd && !dev_stat_rd)
      |=> host_rdata == 32'h0000_00FF);

  assert_task_read_zero_ext_R2: assert property (@(posedge clk) disable iff (rst)
    dev_reg_rd |=> (host_rvalid && host_rdata[31:8] == 24'h0));

  assert_half_read_zero_ext_R6: assert property (@(posedge clk) disable iff (rst)
    (dev_data_rd && !dev_data_wide) |=> host_rdata[31:16] == 16'h0000);

endmodule

// File: tb/tb_mmio_ide_bridge.sv
`timescale 1ns/100ps
module tb_mmio_ide_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [2:0]  dev_reg_idx;
  logic        dev_reg_rd, dev_reg_wr, dev_stat_rd, dev_ctl_wr;
  logic        dev_data_rd, dev_data_wr, dev_data_wide;
  logic [7:0]  dev_reg_wdata, dev_reg_rdata, dev_stat_rdata, dev_ctl_wdata;
  logic [31:0] dev_data_wdata, dev_data_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmio_ide_bridge dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_size(host_size),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .dev_reg_idx(dev_reg_idx), .dev_reg_rd(dev_reg_rd), .dev_reg_wr(dev_reg_wr),
    .dev_reg_wdata(dev_reg_wdata), .dev_reg_rdata(dev_reg_rdata),
    .dev_stat_rd(dev_stat_rd), .dev_stat_rdata(dev_stat_rdata),
    .dev_ctl_wr(dev_ctl_wr), .dev_ctl_wdata(dev_ctl_wdata),
    .dev_data_rd(dev_data_rd), .dev_data_wr(dev_data_wr),
    .dev_data_wide(dev_data_wide), .dev_data_wdata(dev_data_wdata),
    .dev_data_rdata(dev_data_rdata)
  );

  // register-array stub in place of the IDE register file
  logic [7:0]  tf [8];
  logic [7:0]  ctl_q = 8'h00;
  logic [31:0] data_src = 32'h0;
  logic [31:0] data_got = 32'h0;
  logic        wide_got = 1'b0;
  int          strobes = 0;

  initial for (int i = 0; i < 8; i++) tf[i] = 8'h00;

  assign dev_reg_rdata  = tf[dev_reg_idx];
  assign dev_stat_rdata = 8'h50;
  assign dev_data_rdata = data_src;

  always @(posedge clk) begin
    if (dev_reg_wr) tf[dev_reg_idx] <= dev_reg_wdata;
    if (dev_ctl_wr) ctl_q <= dev_ctl_wdata;
    if (dev_data_wr) begin
      data_got <= dev_data_wdata;
      wide_got <= dev_data_wide;
    end
    strobes <= strobes + int'(dev_reg_rd) + int'(dev_reg_wr) + int'(dev_stat_rd)
               + int'(dev_ctl_wr) + int'(dev_data_rd) + int'(dev_data_wr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic rd, input logic wr, input logic [31:0] a,
                     input logic [1:0] sz, input logic [31:0] wd);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 rvalid", {31'h0, host_rvalid}, 32'h0);
    check("R11 rdata", host_rdata, 32'h0);
  endtask

  task automatic t_taskfile;
    int s0;
    s0 = strobes;
    acc(0, 1, 32'h0000_0030, 2'b00, 32'hFFFF_FFA5);
    check("R2 tf3 write", {24'h0, tf[3]}, 32'hA5);
    check("R2 single strobe", s0 + 1, strobes);
    acc(1, 0, 32'hFFFF_F030, 2'b00, 0);
    check("R1 alias read tf3", host_rdata, 32'h0000_00A5);
    acc(0, 1, 32'h0001_201C, 2'b00, 32'h0000_003C);
    check("R1 alias write tf1", {24'h0, tf[1]}, 32'h3C);
    acc(0, 1, 32'h0000_0070, 2'b00, 32'h0000_0077);
    acc(1, 0, 32'h0000_0070, 2'b00, 0);
    check("R2 tf7 read", host_rdata, 32'h0000_0077);
  endtask

  task automatic t_ctlstat;
    acc(0, 1, 32'h0000_0080, 2'b00, 32'h0000_0002);
    check("R3 ctl via slot 8", {24'h0, ctl_q}, 32'h02);
    acc(0, 1, 32'h0000_0160, 2'b00, 32'h0000_0006);
    check("R3 ctl via slot 22", {24'h0, ctl_q}, 32'h06);
    acc(1, 0, 32'h0000_0080, 2'b00, 0);
    check("R3 status slot 8", host_rdata, 32'h0000_0050);
    acc(1, 0, 32'h0000_0164, 2'b00, 0);
    check("R3 status slot 22", host_rdata, 32'h0000_0050);
  endtask

  task automatic t_unmapped_byte;
    int s0;
    acc(1, 0, 32'h0000_0000, 2'b00, 0);
    check("R4 byte read slot 0", host_rdata, 32'h0000_00FF);
    acc(1, 0, 32'h0000_00F0, 2'b00, 0);
    check("R4 byte read slot 15", host_rdata, 32'h0000_00FF);
    s0 = strobes;
    acc(0, 1, 32'h0000_0090, 2'b00, 32'h0000_0011);
    check("R4 byte write slot 9 no strobe", strobes, s0);
    check("R4 ctl untouched", {24'h0, ctl_q}, 32'h06);
  endtask

  task automatic t_data_half;
    data_src = 32'h1234_ABCD;
    acc(1, 0, 32'h0000_0000, 2'b01, 0);
    check("R6 half read swap", host_rdata, 32'h0000_CDAB);
    acc(0, 1, 32'h0000_0002, 2'b01, 32'hFFFF_BEEF);
    check("R6 half write swap", data_got, 32'h0000_EFBE);
    check("R5 half narrow flag", {31'h0, wide_got}, 32'h0);
  endtask

  task automatic t_data_word;
    acc(1, 0, 32'h0000_0000, 2'b10, 0);
    check("R7 word read reverse", host_rdata, 32'hCDAB_3412);
    acc(0, 1, 32'h0000_0000, 2'b10, 32'h1122_3344);
    check("R7 word write reverse", data_got, 32'h4433_2211);
    check("R5 word wide flag", {31'h0, wide_got}, 32'h1);
  endtask

  task automatic t_unmapped_wide;
    int s0;
    acc(1, 0, 32'h0000_0010, 2'b01, 0);
    check("R8 half read off slot 0", host_rdata, 32'h0000_FFFF);
    acc(1, 0, 32'h0000_0020, 2'b10, 0);
    check("R8 word read off slot 0", host_rdata, 32'hFFFF_FFFF);
    acc(1, 0, 32'h0000_0000, 2'b11, 0);
    check("R8 reserved size read", host_rdata, 32'hFFFF_FFFF);
    s0 = strobes;
    acc(0, 1, 32'h0000_0010, 2'b01, 32'h0000_5555);
    acc(0, 1, 32'h0000_0030, 2'b10, 32'h5555_5555);
    check("R8 wide writes dropped", strobes, s0);
    check("R8 tf3 untouched", {24'h0, tf[3]}, 32'hA5);
  endtask

  task automatic t_rvalid;
    acc(1, 0, 32'h0000_0030, 2'b00, 0);
    check("R9 rvalid after read", {31'h0, host_rvalid}, 32'h1);
    check("R9 rdata in valid cycle", host_rdata, 32'h0000_00A5);
    @(negedge clk);
    check("R9 rvalid one cycle", {31'h0, host_rvalid}, 32'h0);
  endtask

  task automatic t_collide;
    int s0;
    s0 = strobes;
    acc(1, 1, 32'h0000_0050, 2'b00, 32'h0000_0077);
    check("R10 write carried out", {24'h0, tf[5]}, 32'h77);
    check("R10 one strobe", strobes, s0 + 1);
    check("R10 no rvalid", {31'h0, host_rvalid}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_taskfile();
    t_ctlstat();
    t_unmapped_byte();
    t_data_half();
    t_data_word();
    t_unmapped_wide();
    t_rvalid();
    t_collide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule